// File: doc/BRIEF.md
# Floating-Point Context Status Tracker

This block keeps the two-bit status field that tells system software whether the floating-point register file holds state that must be saved. It also keeps the summary dirty flag that goes with the field. A second copy of the field and flag is kept for a guest context. Hardware changes that copy only while virtualization is enabled. The execute stage reports each floating-point instruction it issues, and whether that instruction writes floating-point state. The tracker then does three things: it promotes the field to dirty when needed, it mirrors the promotion into the guest copy, and it flags floating-point instructions issued while the unit is switched off as illegal.

Software can load either copy directly through its own write port. A software load overrides any hardware promotion to the same copy in the same cycle. Each copy raises a one-cycle update pulse whenever hardware actually rewrites it. Status-register logic outside the block can use that pulse to know when a write-back happened.

Top module: `fp_ctx_tracker`

## Requirements
- R1: After synchronous reset both copies hold 0 (off), both summary flags are 0, and both update pulses are 0. The encoding is 0 = off, 1 = initial, 2 = clean, 3 = dirty.
- R2: When a floating-point instruction that writes FP state is issued and the primary field is 1 or 2, the primary field is 3 one cycle later. The primary summary flag is 1 in that same cycle and the primary update pulse is high for that cycle.
- R3: When the primary field is already 3, an FP-state-writing instruction leaves it at 3 and produces no primary update pulse.
- R4: A floating-point instruction issued while the primary field is 0 drives the illegal flag high in the same cycle. The field stays 0 and no update pulse follows.
- R5: When virtualization is enabled and a primary promotion (R2) is requested, the guest field becomes 3 and the guest summary flag becomes 1 one cycle later. The guest update pulse is high only if the guest field was not already 3. When virtualization is disabled, hardware never changes the guest copy.
- R6: A software write of the primary field loads the written value one cycle later. The primary summary flag becomes 1 exactly when the written value is 3. The write wins over a same-cycle promotion, and no primary update pulse is produced.
- R7: A software write of the guest field loads the written value one cycle later and wins over a same-cycle guest promotion. The guest summary flag becomes 1 exactly when the written value is 3.
- R8: A floating-point instruction that does not write FP state leaves both fields unchanged.
- R9: The illegal flag is low whenever no floating-point instruction is issued or the primary field is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_issue | input | 1 | A floating-point instruction is issued this cycle |
| fp_writes_state | input | 1 | The issued instruction modifies FP state |
| virt_on | input | 1 | Virtualization enabled; mirror promotions into the guest copy |
| sw_prim_we | input | 1 | Software write strobe, primary field |
| sw_prim_val | input | 2 | Value for the primary field |
| sw_guest_we | input | 1 | Software write strobe, guest field |
| sw_guest_val | input | 2 | Value for the guest field |
| prim_state | output | 2 | Primary status field |
| prim_sum | output | 1 | Primary summary dirty flag |
| prim_hw_upd | output | 1 | Hardware rewrote the primary copy in the last cycle |
| guest_state | output | 2 | Guest status field |
| guest_sum | output | 1 | Guest summary dirty flag |
| guest_hw_upd | output | 1 | Hardware rewrote the guest copy in the last cycle |
| fp_illegal | output | 1 | Issued FP instruction is illegal because the unit is off |

## Verification
Several rules are checked by assertions on every cycle: promotion to dirty, holding when already dirty, the same-cycle illegal flag, mirroring into the guest copy, software-write priority, and the guest copy staying frozen while virtualization is off. Those properties only cover cycles where their trigger conditions actually occur. The bench is needed to show that every combination of starting states, virtualization setting, instruction kind and software override gives the right state, summary flag and pulse. That includes the guest update pulse being suppressed when the guest copy is already dirty.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

    localparam int FS_W    = 2;
    localparam int N_COPY  = 2;
    localparam int PRIM    = 0;
    localparam int GUEST   = 1;

    typedef enum logic [FS_W-1:0] {
        FS_OFF   = 2'd0,
        FS_INIT  = 2'd1,
        FS_CLEAN = 2'd2,
        FS_DIRTY = 2'd3
    } fs_e;

    typedef struct packed {
        logic wr_en;
        fs_e  val;
    } sw_wr_t;

    typedef struct packed {
        fs_e  st;
        logic sum;
        logic hw_upd;
    } cell_out_t;

    function automatic logic can_promote(input fs_e s);
        return (s == FS_INIT) || (s == FS_CLEAN);
    endfunction

    function automatic logic is_dirty(input fs_e s);
        return s == FS_DIRTY;
    endfunction

endpackage

// File: rtl/fs_promote_ctl.sv
module fs_promote_ctl
    import fpst_pkg::*;
#(
    parameter int NC = N_COPY
) (
    input  logic          fp_issue,
    input  logic          fp_writes_state,
    input  logic          virt_on,
    input  fs_e           prim_cur,
    output logic          illegal,
    output logic [NC-1:0] hw_req
);
    logic base_req;

    always_comb begin
        illegal  = fp_issue && (prim_cur == FS_OFF);
        base_req = fp_issue && fp_writes_state && can_promote(prim_cur);
    end

    for (genvar g = 0; g < NC; g++) begin : g_req
        if (g == 0) begin : g_prim
            assign hw_req[g] = base_req;
        end else begin : g_shadow
            assign hw_req[g] = base_req && virt_on;
        end
    end
endmodule

// File: rtl/fs_status_cell.sv
module fs_status_cell
    import fpst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hw_req,
    input  sw_wr_t    sw,
    output cell_out_t q
);
    fs_e  st_q;
    logic sum_q;
    logic upd_q;
    fs_e  st_d;
    logic upd_d;

    always_comb begin
        st_d  = st_q;
        upd_d = 1'b0;
        if (sw.wr_en) begin
            st_d = sw.val;
        end else if (hw_req && !is_dirty(st_q)) begin
            st_d  = FS_DIRTY;
            upd_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FS_OFF;
            sum_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            sum_q <= is_dirty(st_d);
            upd_q <= upd_d;
        end
    end

    assign q = '{st: st_q, sum: sum_q, hw_upd: upd_q};
endmodule

// File: rtl/fp_ctx_tracker.sv
module fp_ctx_tracker
    import fpst_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fp_issue,
    input  logic            fp_writes_state,
    input  logic            virt_on,
    input  logic            sw_prim_we,
    input  logic [FS_W-1:0] sw_prim_val,
    input  logic            sw_guest_we,
    input  logic [FS_W-1:0] sw_guest_val,
    output logic [FS_W-1:0] prim_state,
    output logic            prim_sum,
    output logic            prim_hw_upd,
    output logic [FS_W-1:0] guest_state,
    output logic            guest_sum,
    output logic            guest_hw_upd,
    output logic            fp_illegal
);
    logic [N_COPY-1:0] hw_req;
    sw_wr_t            sw_bus [N_COPY];
    cell_out_t         cell_q [N_COPY];

    assign sw_bus[PRIM]  = '{wr_en: sw_prim_we,  val: fs_e'(sw_prim_val)};
    assign sw_bus[GUEST] = '{wr_en: sw_guest_we, val: fs_e'(sw_guest_val)};

    fs_promote_ctl #(.NC(N_COPY)) u_ctl (
        .fp_issue        (fp_issue),
        .fp_writes_state (fp_writes_state),
        .virt_on         (virt_on),
        .prim_cur        (cell_q[PRIM].st),
        .illegal         (fp_illegal),
        .hw_req          (hw_req)
    );

    for (genvar c = 0; c < N_COPY; c++) begin : g_cell
        fs_status_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .hw_req (hw_req[c]),
            .sw     (sw_bus[c]),
            .q      (cell_q[c])
        );
    end

    assign prim_state   = cell_q[PRIM].st;
    assign prim_sum     = cell_q[PRIM].sum;
    assign prim_hw_upd  = cell_q[PRIM].hw_upd;
    assign guest_state  = cell_q[GUEST].st;
    assign guest_sum    = cell_q[GUEST].sum;
    assign guest_hw_upd = cell_q[GUEST].hw_upd;
endmodule

// File: rtl/fp_ctx_tracker_chk.sv
module fp_ctx_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       fp_issue,
    input logic       fp_writes_state,
    input logic       virt_on,
    input logic       sw_prim_we,
    input logic [1:0] sw_prim_val,
    input logic       sw_guest_we,
    input logic [1:0] sw_guest_val,
    input logic [1:0] prim_state,
    input logic       prim_sum,
    input logic       prim_hw_upd,
    input logic [1:0] guest_state,
    input logic       guest_sum,
    input logic       guest_hw_upd,
    input logic       fp_illegal
);
    AST_PROMOTE_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (fp_issue && fp_writes_state && !sw_prim_we && (prim_state == 2'd1 || prim_state == 2'd2))
        |=> (prim_state == 2'd3 && prim_sum && prim_hw_upd)); // R2

    AST_DIRTY_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        (fp_issue && fp_writes_state && !sw_prim_we && prim_state == 2'd3)
        |=> (prim_state == 2'd3 && !prim_hw_upd)); // R3

    AST_OFF_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (fp_issue && prim_state == 2'd0) |-> fp_illegal); // R4

    AST_OFF_STAYS: assert property (@(posedge clk) disable iff (rst)
        (fp_issue && prim_state == 2'd0 && !sw_prim_we)
        |=> (prim_state == 2'd0 && !prim_hw_upd)); // R4

    AST_GUEST_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (fp_issue && fp_writes_state && virt_on && !sw_guest_we
         && (prim_state == 2'd1 || prim_state == 2'd2))
        |=> (guest_state == 2'd3 && guest_sum)); // R5

    AST_GUEST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!virt_on && !sw_guest_we) |=> ($stable(guest_state) && !guest_hw_upd)); // R5

    AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        sw_prim_we |=> (prim_state == $past(sw_prim_val) && !prim_hw_upd
                        && prim_sum == ($past(sw_prim_val) == 2'd3))); // R6

    AST_GUEST_SW: assert property (@(posedge clk) disable iff (rst)
        sw_guest_we |=> (guest_state == $past(sw_guest_val) && !guest_hw_upd)); // R7

    AST_NOWRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fp_issue && !fp_writes_state && !sw_prim_we && !sw_guest_we)
        |=> ($stable(prim_state) && $stable(guest_state))); // R8

    AST_ILLEGAL_ONLY_OFF: assert property (@(posedge clk) disable iff (rst)
        fp_illegal |-> (fp_issue && prim_state == 2'd0)); // R9
endmodule

bind fp_ctx_tracker fp_ctx_tracker_chk u_chk (.*);

// File: tb/fp_ctx_tracker_tb.sv
module fp_ctx_tracker_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fp_issue = 1'b0;
    logic       fp_writes_state = 1'b0;
    logic       virt_on = 1'b0;
    logic       sw_prim_we = 1'b0;
    logic [1:0] sw_prim_val = 2'd0;
    logic       sw_guest_we = 1'b0;
    logic [1:0] sw_guest_val = 2'd0;
    logic [1:0] prim_state;
    logic       prim_sum;
    logic       prim_hw_upd;
    logic [1:0] guest_state;
    logic       guest_sum;
    logic       guest_hw_upd;
    logic       fp_illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fp_ctx_tracker u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fp_issue = 0; fp_writes_state = 0; virt_on = 0;
        sw_prim_we = 0; sw_guest_we = 0;
    endtask

    task automatic load_states(input logic [1:0] p, input logic [1:0] s);
        @(negedge clk);
        idle_inputs();
        sw_prim_we = 1; sw_prim_val = p;
        sw_guest_we = 1; sw_guest_val = s;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", {2'b0, prim_state, prim_sum, prim_hw_upd, 2'b0}, 8'h00);
        chk("R1", {2'b0, guest_state, guest_sum, guest_hw_upd, 2'b0}, 8'h00);

        for (int p = 0; p < 4; p++)
        for (int s = 0; s < 4; s++)
        for (int v = 0; v < 2; v++)
        for (int k = 0; k < 3; k++)
        for (int o = 0; o < 2; o++) begin
            logic op, wr, prom, e_ill, e_pupd, e_gupd;
            logic [1:0] nv, e_p, e_g;
            load_states(p[1:0], s[1:0]);
            op = (k >= 1);
            wr = (k == 2);
            nv = 2'(p + 1);
            prom   = wr && (p == 1 || p == 2);
            e_ill  = op && (p == 0);
            e_p    = o ? nv : (prom ? 2'd3 : p[1:0]);
            e_pupd = prom && !o;
            e_g    = (prom && v) ? 2'd3 : s[1:0];
            e_gupd = prom && v && (s != 3);
            fp_issue = op; fp_writes_state = wr; virt_on = v[0];
            sw_prim_we = o[0]; sw_prim_val = nv;
            #1;
            // R4 / R9: same-cycle illegal flag
            chk(e_ill ? "R4" : "R9", {7'b0, fp_illegal}, {7'b0, e_ill});
            @(negedge clk);
            idle_inputs();
            // R2 R3 R4 R6 R8: primary state and summary
            chk(o ? "R6" : (prom ? "R2" : (p == 3 ? "R3" : "R8")),
                {4'b0, prim_state, prim_sum, prim_hw_upd},
                {4'b0, e_p, (e_p == 2'd3), e_pupd});
            // R5 R8: guest copy
            chk(prom && v ? "R5" : "R8",
                {4'b0, guest_state, guest_sum, guest_hw_upd},
                {4'b0, e_g, (e_g == 2'd3), e_gupd});
        end

        // R7: guest software write beats mirrored promotion
        for (int gv = 0; gv < 4; gv++) begin
            load_states(2'd1, 2'd2);
            fp_issue = 1; fp_writes_state = 1; virt_on = 1;
            sw_guest_we = 1; sw_guest_val = gv[1:0];
            @(negedge clk);
            idle_inputs();
            chk("R7", {4'b0, guest_state, guest_sum, guest_hw_upd},
                {4'b0, gv[1:0], (gv == 3), 1'b0});
            chk("R2", {6'b0, prim_state}, 8'h03);
        end

        // R1: reset again from dirty
        load_states(2'd3, 2'd3);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R1", {2'b0, prim_state, prim_sum, guest_state, guest_sum}, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule